// File: doc/BRIEF.md
# Offset Programmable Clock Post-Divider

This block derives a slower output-bank clock from a fast input clock. A programmable first stage counts off a half-period whose length is the programmed divide value plus two input cycles. Each time that stage reaches its terminal count, a toggle flop flips. The output clock therefore always has a 50% duty cycle, and its total ratio to the input is 2*(Q+2).

The divide value is taken into use only at a terminal count, so reprogramming it on the fly never shortens or stretches the half-period already under way. An enable input parks the output low and holds the counter cleared. This is meant for banks that are never used in normal operation. While the block is parked it follows the divide input on every edge. When it is enabled again, it produces a clean first half-period of the programmed length.

Top module: `postdiv_top`

## Requirements
- R1: While the active-low reset is asserted, the output clock is low. It stays low through the release of reset while enable is low.
- R2: While enabled with a steady divide value Q, every high phase and every low phase of the output lasts exactly Q+2 input clock cycles. This gives a total ratio of 2*(Q+2) and 50% duty.
- R3: The divide field is 10 bits. Q = 0 gives half-periods of 2 cycles (ratio 4), and Q = 1023 gives half-periods of 1025 cycles (ratio 2050).
- R4: The divide value is captured at the edge where the output toggles. A new Q applied after a toggle leaves the next half-period at the old length, and every half-period after that uses the new length.
- R5: At the first rising clock edge where enable is sampled low, the output goes low. It stays low for as long as enable remains low, whatever Q does.
- R6: While disabled, Q is sampled on every edge. The first rising output edge after enable comes on the (Q+2)-th rising clock edge at which enable is sampled high.
- R7: The output changes only at a first-stage terminal count or when the block is disabled. The first-stage count never exceeds Q+1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock to be divided |
| rstN | input | 1 | Asynchronous active-low reset |
| divQ | input | 10 | Programmed divide value Q; the half-period is Q+2 cycles |
| enable | input | 1 | High runs the divider; low parks the output low |
| clkOut | output | 1 | Divided clock with 50% duty |

## Verification
The output is registered, so each result lands on a rising edge. A disable shows up one edge after enable is sampled low. The first high phase begins Q+2 edges after enable is first sampled high, and every later toggle follows the previous one by Q+2 edges, using the Q captured at that previous toggle. The bench drives inputs and samples the output on falling edges. It measures each phase by counting rising edges until the output changes and compares that count with Q+2 for the Q that governs that phase. Any reprogramming is done just after an observed toggle, so the expected old-then-new sequence is exact.

// File: rtl/postdiv_pkg.sv
package postdiv_pkg;

  // Strobes the control stage hands to the datapath each cycle.
  typedef struct packed {
    logic clear;    // park: counter and output cleared, divisor follows input
    logic wrap;     // terminal count: restart counter, flip output, capture divisor
    logic advance;  // ordinary count step
  } divStrobe_t;

endpackage

// File: rtl/postdiv_ctrl.sv
module postdiv_ctrl
  import postdiv_pkg::*;
#(
  parameter int CW = 11
) (
  input  logic          enable,
  input  logic [CW-1:0] cnt,
  input  logic [CW-1:0] lastCnt,
  output divStrobe_t    strobe
);

  logic atTerminal;

  assign atTerminal = (cnt == lastCnt);

  always_comb begin
    strobe         = '0;
    if (!enable) begin
      strobe.clear   = 1'b1;
    end else if (atTerminal) begin
      strobe.wrap    = 1'b1;
    end else begin
      strobe.advance = 1'b1;
    end
  end

endmodule

// File: rtl/postdiv_dp.sv
module postdiv_dp
  import postdiv_pkg::*;
#(
  parameter int QW = 10,
  parameter int CW = QW + 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [QW-1:0] divQ,
  input  divStrobe_t    strobe,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] lastCnt,
  output logic [QW-1:0] activeQ,
  output logic          clkOut
);

  logic toggleQ;

  // Last count value of a half-period: (Q + 2) - 1.
  assign lastCnt = {1'b0, activeQ} + CW'(1);
  assign clkOut  = toggleQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt     <= '0;
      toggleQ <= 1'b0;
      activeQ <= '0;
    end else if (strobe.clear) begin
      cnt     <= '0;
      toggleQ <= 1'b0;
      activeQ <= divQ;
    end else if (strobe.wrap) begin
      cnt     <= '0;
      toggleQ <= ~toggleQ;
      activeQ <= divQ;
    end else if (strobe.advance) begin
      cnt     <= cnt + CW'(1);
    end
  end

endmodule

// File: rtl/postdiv_top.sv
module postdiv_top
  import postdiv_pkg::*;
#(
  parameter int QW = 10
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [QW-1:0] divQ,
  input  logic          enable,
  output logic          clkOut
);

  localparam int CW = QW + 1;

  divStrobe_t    strobe;
  logic [CW-1:0] cnt;
  logic [CW-1:0] lastCnt;
  logic [QW-1:0] activeQ;

  postdiv_ctrl #(.CW(CW)) u_ctrl (
    .enable  (enable),
    .cnt     (cnt),
    .lastCnt (lastCnt),
    .strobe  (strobe)
  );

  postdiv_dp #(.QW(QW), .CW(CW)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .divQ    (divQ),
    .strobe  (strobe),
    .cnt     (cnt),
    .lastCnt (lastCnt),
    .activeQ (activeQ),
    .clkOut  (clkOut)
  );

endmodule

// File: rtl/postdiv_checker.sv
module postdiv_checker #(
  parameter int QW = 10,
  parameter int CW = QW + 1
) (
  input logic          clk,
  input logic          rstN,
  input logic          enable,
  input logic          clkOut,
  input logic [CW-1:0] cnt,
  input logic [QW-1:0] activeQ
);

  logic [CW-1:0] termVal;
  assign termVal = {1'b0, activeQ} + CW'(1);

  // R5: a sampled-low enable parks the output low at the next edge
  a_r5_park_low: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !clkOut);

  // R6: a parked divider restarts its count from zero
  a_r6_park_clears: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (cnt == '0));

  // R7: the count never passes the terminal value
  a_r7_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= termVal);

  // R7: no output change away from the terminal count
  a_r7_no_mid_toggle: assert property (@(posedge clk) disable iff (!rstN)
    (enable && cnt != termVal) |=> $stable(clkOut));

  // R2: the terminal count always flips the output
  a_r2_terminal_flips: assert property (@(posedge clk) disable iff (!rstN)
    (enable && cnt == termVal) |=> (clkOut != $past(clkOut)));

  // R4: the divisor in use holds still within a half-period
  a_r4_divisor_held: assert property (@(posedge clk) disable iff (!rstN)
    (enable && cnt != termVal) |=> $stable(activeQ));

endmodule

bind postdiv_top postdiv_checker #(.QW(QW), .CW(CW)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .enable  (enable),
  .clkOut  (clkOut),
  .cnt     (cnt),
  .activeQ (activeQ)
);

// File: tb/tb_postdiv_top.sv
`timescale 1ns/1ps
module tb_postdiv_top;

  localparam int QW = 10;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [QW-1:0] divQ = '0;
  logic          enable = 1'b0;
  logic          clkOut;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  postdiv_top #(.QW(QW)) dut (
    .clk    (clk),
    .rstN   (rstN),
    .divQ   (divQ),
    .enable (enable),
    .clkOut (clkOut)
  );

  always #10 clk = ~clk;  // 50 MHz

  function automatic int halfLen(input int q);
    return q + 2;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Count rising edges until the output changes; sampled on falling edges.
  task automatic edgesToToggle(output int n);
    logic prev;
    prev = clkOut;
    n = 0;
    do begin
      @(posedge clk);
      @(negedge clk);
      n++;
    end while (clkOut == prev && n < 3000);
  endtask

  task automatic expectHalf(input int exp, input string req);
    int n;
    edgesToToggle(n);
    check(n == exp, req, n, exp);
  endtask

  task automatic parkAndLoad(input int q);
    enable = 1'b0;
    repeat (2) @(negedge clk);
    divQ = QW'(q);
    @(negedge clk);
    enable = 1'b1;
  endtask

  initial begin
    int n;
    void'($urandom(32'h5eed_0042));
    divQ = 10'd5;
    repeat (3) @(negedge clk);
    check(clkOut == 1'b0, "R1", int'(clkOut), 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check(clkOut == 1'b0, "R1", int'(clkOut), 0);

    // R6 first edge after enable, R2 steady halves
    divQ = 10'd3;
    @(negedge clk);
    enable = 1'b1;
    expectHalf(halfLen(3), "R6");
    check(clkOut == 1'b1, "R6", int'(clkOut), 1);
    for (int i = 0; i < 4; i++) expectHalf(halfLen(3), "R2");

    // R4 reprogram just after a toggle
    divQ = 10'd7;
    expectHalf(halfLen(3), "R4");
    expectHalf(halfLen(7), "R4");
    expectHalf(halfLen(7), "R4");

    // R5 disable while high
    if (clkOut == 1'b0) expectHalf(halfLen(7), "R2");
    enable = 1'b0;
    @(negedge clk);
    check(clkOut == 1'b0, "R5", int'(clkOut), 0);
    for (int i = 0; i < 20; i++) begin
      divQ = QW'($urandom % 4);
      @(negedge clk);
      check(clkOut == 1'b0, "R5", int'(clkOut), 0);
    end

    // R3 minimum
    parkAndLoad(0);
    for (int i = 0; i < 4; i++) expectHalf(halfLen(0), "R3");

    // R3 maximum
    parkAndLoad(1023);
    for (int i = 0; i < 3; i++) expectHalf(halfLen(1023), "R3");

    // Random Q with on-the-fly changes
    for (int it = 0; it < 20; it++) begin
      int q1, q2;
      q1 = int'($urandom % 64);
      q2 = int'($urandom % 64);
      parkAndLoad(q1);
      expectHalf(halfLen(q1), "R6");
      expectHalf(halfLen(q1), "R2");
      divQ = QW'(q2);
      expectHalf(halfLen(q1), "R4");
      expectHalf(halfLen(q2), "R4");
      expectHalf(halfLen(q2), "R2");
    end

    n = 0;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule